// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end through which a host reaches the registers of a switch-style device. The registers sit behind a two-level address of block and subblock. Each SPI frame opens with a command byte and a register byte. A write frame then carries four data bytes. A read frame carries two zero pad bytes, after which the slave shifts out four bytes of register data. The block turns each frame into one single-cycle strobe on a simple parallel register bus. That bus carries block, subblock, register and write-data fields.

The serial pins are sampled in the system clock domain through synchronizer chains. Edges are detected there, and the bit shifter and the frame controller act on them. The block does not pass on an address whose block and subblock pair is illegal. Such a frame creates no strobe, and a read of it returns zeros.

A small register model sits behind the bus so that the whole path can be checked end to end. It has a read-only identity word, a byte memory reached through an auto-incrementing pointer, and one 32-bit scratch word.

Top module: `spi_reg_slave`

## Requirements
- R1: SPI mode 0, MSB first. The command byte gives the block in bits 7:5, the direction in bit 4 (1 = write, 0 = read) and the subblock in bits 3:0. The second byte is the register number. During every strobe, `bus_block`, `bus_sub` and `bus_reg` show these fields.
- R2: A write frame is command, register, then four data bytes, most significant first. Once the fourth data byte is complete, `bus_wr` pulses for one cycle with the assembled word on `bus_wdata`.
- R3: A read frame is command, register, two pad bytes, then four returned bytes, most significant first. `bus_rd` pulses once the register byte is complete, before the first pad byte begins.
- R4: The legal pairs are: block 1 with subblock 0, 1, 2, 3, 4 or 6; block 2 or block 7 with subblock 0; block 3, 4 or 5 with subblock 0 or 1. Every other pair produces no strobe, and a read of it returns zero.
- R5: If chip select goes high before a frame is complete, the partial frame is dropped with no strobe, and the next frame starts again at the command byte.
- R6: Block 7, subblock 0, register 0x18 reads as the identity word: revision in bits 31:28, device code (default 0x7385) in bits 27:12, zeros below. Writes to it have no effect.
- R7: Block 7, subblock 0, register 0x11 is the memory pointer, readable and writable. Register 0x12 is the memory port. A write stores `wdata[7:0]` at the pointer. A read returns that byte zero-extended. Each port access advances the pointer, which wraps modulo the memory depth.
- R8: Block 1, subblock 6, register 0x00 is a 32-bit scratch word that reads back the last value written to it.
- R9: After reset, both strobes are low, MISO is low and the bus address outputs are zero.
- R10: Bytes sent after a frame's defined length create no further strobes, and MISO stays low during them.
- R11: `bus_wr` and `bus_rd` are never high together, and each lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_block | output | 3 | Register-bus block field |
| bus_sub | output | 4 | Register-bus subblock field |
| bus_reg | output | 8 | Register-bus register number |
| bus_wdata | output | 32 | Register-bus write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |

## Verification
A rising SCLK edge reaches the receive shifter on the third clock edge, because two synchronizer flops and one edge-history flop lie in the path. The strobe for that byte appears on the fourth edge. The read word is captured on the fifth. A falling SCLK edge updates MISO three edges after the pin changes. The bench holds each SCLK phase for ten clocks, samples MISO at the very end of the low phase and counts strobes in a negative-edge monitor. Every result therefore settles several cycles before it is examined. The early read strobe is confirmed by taking the strobe count after the register byte and before any pad bit is clocked.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  typedef struct packed {
    logic [2:0] blk;
    logic       wr;
    logic [3:0] sub;
  } cmd_t;

  localparam logic [2:0] BLK_MAC     = 3'd1;
  localparam logic [2:0] BLK_SYS     = 3'd7;
  localparam logic [3:0] SUB_HOST    = 4'd6;
  localparam logic [7:0] REG_SCRATCH = 8'h00;
  localparam logic [7:0] REG_PTR     = 8'h11;
  localparam logic [7:0] REG_PORT    = 8'h12;
  localparam logic [7:0] REG_IDENT   = 8'h18;

  // legality map of block/subblock pairs
  function automatic logic addr_legal(input logic [2:0] b, input logic [3:0] s);
    case (b)
      3'd1:             return (s <= 4'd4) || (s == 4'd6);
      3'd2, 3'd7:       return (s == 4'd0);
      3'd3, 3'd4, 3'd5: return (s <= 4'd1);
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ident_word(input logic [15:0] dev, input logic [3:0] rev);
    return {rev, dev, 12'h000};
  endfunction

  // lane 0 is the most significant byte
  function automatic logic [7:0] word_lane(input logic [31:0] w, input logic [1:0] lane);
    return w[8*(3-lane) +: 8];
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_ff, cs_ff, mosi_ff;
  logic              sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_ff   <= '0;
      cs_ff     <= '1;
      mosi_ff   <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_ff   <= {sclk_ff[STAGES-2:0], sclk_i};
      cs_ff     <= {cs_ff[STAGES-2:0], cs_n_i};
      mosi_ff   <= {mosi_ff[STAGES-2:0], mosi_i};
      sclk_prev <= sclk_ff[STAGES-1];
    end
  end

  assign cs_act    = ~cs_ff[STAGES-1];
  assign mosi_s    = mosi_ff[STAGES-1];
  assign sclk_rise = cs_act & sclk_ff[STAGES-1] & ~sclk_prev;
  assign sclk_fall = cs_act & ~sclk_ff[STAGES-1] & sclk_prev;
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_act,
  input  logic         rise,
  input  logic         fall,
  input  logic         mosi_s,
  input  logic [W-1:0] tx_byte,
  output logic [W-1:0] rx_byte,
  output logic         rx_done,
  output logic         miso
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rx_byte <= '0;
      rx_done <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (rise) begin
        rx_sh <= {rx_sh[W-2:0], mosi_s};
        if (bit_cnt == LAST) begin
          bit_cnt <= '0;
          rx_done <= 1'b1;
          rx_byte <= {rx_sh[W-2:0], mosi_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (fall) begin
        // mode 0: next bit appears on the falling edge; a new byte at the boundary
        tx_sh <= (bit_cnt == '0) ? tx_byte : {tx_sh[W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[W-1];

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R5
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0) && !miso);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_rb_pkg::*;
#(
  parameter int FRAME_CAP = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_act,
  input  logic        rx_done,
  input  logic [7:0]  rx_byte,
  input  logic [31:0] rd_word,
  output logic [7:0]  tx_byte,
  output logic [2:0]  bus_block,
  output logic [3:0]  bus_sub,
  output logic [7:0]  bus_reg,
  output logic [31:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd
);
  localparam int IDXW = $clog2(FRAME_CAP + 1);
  localparam logic [IDXW-1:0] I_CMD   = IDXW'(0);
  localparam logic [IDXW-1:0] I_REG   = IDXW'(1);
  localparam logic [IDXW-1:0] I_DAT0  = IDXW'(2);
  localparam logic [IDXW-1:0] I_DLAST = IDXW'(5);
  localparam logic [IDXW-1:0] I_RD0   = IDXW'(4);
  localparam logic [IDXW-1:0] I_RDL   = IDXW'(7);
  localparam logic [IDXW-1:0] I_CAP   = IDXW'(FRAME_CAP);

  logic [IDXW-1:0] byte_idx;
  cmd_t            cmd_q;
  logic [7:0]      reg_q;
  logic [31:0]     wsh, rword;
  logic            cmd_legal;
  logic [IDXW-1:0] lane_idx;

  assign cmd_legal = addr_legal(cmd_q.blk, cmd_q.sub);
  assign lane_idx  = byte_idx - I_RD0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= '0;
      cmd_q    <= '0;
      reg_q    <= '0;
      wsh      <= '0;
      rword    <= '0;
      bus_wr   <= 1'b0;
      bus_rd   <= 1'b0;
    end else if (!cs_act) begin
      byte_idx <= '0;
      bus_wr   <= 1'b0;
      bus_rd   <= 1'b0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      if (bus_rd) rword <= rd_word;
      if (rx_done) begin
        if (byte_idx != I_CAP) byte_idx <= byte_idx + 1'b1;
        if (byte_idx == I_CMD) begin
          cmd_q <= cmd_t'(rx_byte);
        end else if (byte_idx == I_REG) begin
          reg_q <= rx_byte;
          if (!cmd_q.wr) begin
            rword  <= '0;
            bus_rd <= cmd_legal;
          end
        end else if (cmd_q.wr && byte_idx >= I_DAT0 && byte_idx <= I_DLAST) begin
          wsh <= {wsh[23:0], rx_byte};
          if (byte_idx == I_DLAST) bus_wr <= cmd_legal;
        end
      end
    end
  end

  always_comb begin
    tx_byte = 8'h00;
    if (!cmd_q.wr && byte_idx >= I_RD0 && byte_idx <= I_RDL)
      tx_byte = word_lane(rword, lane_idx[1:0]);
  end

  assign bus_block = cmd_q.blk;
  assign bus_sub   = cmd_q.sub;
  assign bus_reg   = reg_q;
  assign bus_wdata = wsh;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  // R4
  legal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> addr_legal(bus_block, bus_sub));

  // R5
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !bus_wr && !bus_rd && (byte_idx == '0));

  // R10
  tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_idx > I_RDL) |-> (tx_byte == 8'h00) && !bus_wr && !bus_rd);
endmodule

// File: rtl/spi_reg_model.sv
module spi_reg_model
  import spi_rb_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter logic [15:0] DEV_CODE = 16'h7385,
  parameter logic [3:0]  REV_ID   = 4'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  blk,
  input  logic [3:0]  sub,
  input  logic [7:0]  rsel,
  input  logic [31:0] wdata,
  input  logic        wr,
  input  logic        rd,
  output logic [31:0] rd_word
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [31:0]   scratch;
  logic          sel_sys, sel_scr, port_hit;

  assign sel_sys  = (blk == BLK_SYS) && (sub == 4'd0);
  assign sel_scr  = (blk == BLK_MAC) && (sub == SUB_HOST) && (rsel == REG_SCRATCH);
  assign port_hit = sel_sys && (rsel == REG_PORT) && (wr || rd);

  always_comb begin
    rd_word = '0;
    if (sel_sys) begin
      case (rsel)
        REG_IDENT: rd_word = ident_word(DEV_CODE, REV_ID);
        REG_PTR:   rd_word = {{(32-AW){1'b0}}, ptr};
        REG_PORT:  rd_word = {24'h0, mem[ptr]};
        default:   rd_word = '0;
      endcase
    end else if (sel_scr) begin
      rd_word = scratch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      scratch <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (wr && sel_scr) scratch <= wdata;
      if (wr && sel_sys && rsel == REG_PTR) ptr <= wdata[AW-1:0];
      if (wr && port_hit) mem[ptr] <= wdata[7:0];
      if (port_hit) ptr <= ptr + 1'b1;
    end
  end

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int          SYNC_STAGES = 2,
  parameter int          FRAME_CAP   = 15,
  parameter int          MEM_DEPTH   = 16,
  parameter logic [15:0] DEV_CODE    = 16'h7385,
  parameter logic [3:0]  REV_ID      = 4'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [2:0]  bus_block,
  output logic [3:0]  bus_sub,
  output logic [7:0]  bus_reg,
  output logic [31:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd
);
  logic        sclk_rise, sclk_fall, cs_act, mosi_s;
  logic        rx_done;
  logic [7:0]  rx_byte, tx_byte;
  logic [31:0] rd_word;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s));

  spi_bit_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(sclk_rise), .fall(sclk_fall),
    .mosi_s(mosi_s), .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_done(rx_done),
    .miso(spi_miso));

  spi_frame_ctrl #(.FRAME_CAP(FRAME_CAP)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_done(rx_done), .rx_byte(rx_byte),
    .rd_word(rd_word), .tx_byte(tx_byte), .bus_block(bus_block), .bus_sub(bus_sub),
    .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd));

  spi_reg_model #(.DEPTH(MEM_DEPTH), .DEV_CODE(DEV_CODE), .REV_ID(REV_ID)) u_model (
    .clk(clk), .rst_n(rst_n), .blk(bus_block), .sub(bus_sub), .rsel(bus_reg),
    .wdata(bus_wdata), .wr(bus_wr), .rd(bus_rd), .rd_word(rd_word));
endmodule

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;
  localparam int HALF = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, bus_wr, bus_rd;
  logic [2:0] bus_block;
  logic [3:0] bus_sub;
  logic [7:0] bus_reg;
  logic [31:0] bus_wdata;

  always #2.5 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_block(bus_block),
    .bus_sub(bus_sub), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd));

  int checks = 0, errors = 0, both_hi = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [2:0] cap_blk; logic [3:0] cap_sub; logic [7:0] cap_reg; logic [31:0] cap_wd;
  bit done = 0;

  always @(negedge clk) begin
    if (bus_wr && bus_rd) both_hi++;
    if (bus_wr || bus_rd) begin
      cap_blk = bus_block; cap_sub = bus_sub; cap_reg = bus_reg; cap_wd = bus_wdata;
    end
    if (bus_wr) wr_cnt++;
    if (bus_rd) rd_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      #HALF;
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      #HALF;
      spi_sclk = 1'b0;
    end
  endtask

  // nb: bytes sent; data returned from bytes 4..7 of a read frame
  task automatic frame(input bit w, input logic [2:0] b, input logic [3:0] s,
                       input logic [7:0] r, input logic [31:0] d, input int nb,
                       output logic [31:0] rdat, output int early_rd,
                       output logic [7:0] tail);
    logic [7:0] rx;
    int rd0;
    rdat = '0; tail = '0;
    rd0 = rd_cnt;
    spi_cs_n = 1'b0;
    #HALF;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] tb;
      case (k)
        0: tb = {b, w, s};
        1: tb = r;
        2, 3, 4, 5: tb = w ? d[8*(5-k) +: 8] : 8'h00;
        default: tb = 8'h00;
      endcase
      xbyte(tb, rx);
      if (k == 1) begin #(HALF/2); early_rd = rd_cnt - rd0; end
      if (!w && k >= 4 && k <= 7) rdat[8*(7-k) +: 8] = rx;
      if (k >= 8) tail = tail | rx;
    end
    #HALF;
    spi_cs_n = 1'b1;
    #(4*HALF);
  endtask

  // {wr, blk, sub, reg, data, legal, expected}
  localparam int NV = 18;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 3'd1, 4'd6, 8'h00, 32'hDEADBEEF, 1'b1, 32'h0},
    {1'b0, 3'd1, 4'd6, 8'h00, 32'h0,        1'b1, 32'hDEADBEEF},
    {1'b0, 3'd7, 4'd0, 8'h18, 32'h0,        1'b1, 32'h17385000},
    {1'b1, 3'd7, 4'd0, 8'h11, 32'h3,        1'b1, 32'h0},
    {1'b1, 3'd7, 4'd0, 8'h12, 32'h123456A5, 1'b1, 32'h0},
    {1'b1, 3'd7, 4'd0, 8'h12, 32'h0000003C, 1'b1, 32'h0},
    {1'b1, 3'd7, 4'd0, 8'h11, 32'h3,        1'b1, 32'h0},
    {1'b0, 3'd7, 4'd0, 8'h12, 32'h0,        1'b1, 32'h000000A5},
    {1'b0, 3'd7, 4'd0, 8'h12, 32'h0,        1'b1, 32'h0000003C},
    {1'b0, 3'd7, 4'd0, 8'h11, 32'h0,        1'b1, 32'h00000005},
    {1'b1, 3'd1, 4'd5, 8'h00, 32'hFFFFFFFF, 1'b0, 32'h0},
    {1'b0, 3'd0, 4'd0, 8'h18, 32'h0,        1'b0, 32'h0},
    {1'b0, 3'd7, 4'd1, 8'h18, 32'h0,        1'b0, 32'h0},
    {1'b1, 3'd7, 4'd0, 8'h18, 32'h0,        1'b1, 32'h0},
    {1'b0, 3'd7, 4'd0, 8'h18, 32'h0,        1'b1, 32'h17385000},
    {1'b0, 3'd3, 4'd1, 8'h00, 32'h0,        1'b1, 32'h0},
    {1'b0, 3'd2, 4'd1, 8'h00, 32'h0,        1'b0, 32'h0},
    {1'b0, 3'd5, 4'd2, 8'h00, 32'h0,        1'b0, 32'h0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rdat; int early; logic [7:0] tail; int w0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!bus_wr && !bus_rd && !spi_miso, "R9 strobes/miso", {bus_wr, bus_rd, spi_miso}, 0);
    chk({bus_block, bus_sub, bus_reg} == 0, "R9 address", {bus_block, bus_sub, bus_reg}, 0);

    for (int v = 0; v < NV; v++) begin
      logic w, lg; logic [2:0] b; logic [3:0] s; logic [7:0] r; logic [31:0] d, e;
      string tag;
      {w, b, s, r, d, lg, e} = VEC[v];
      if (!lg) tag = "R4";
      else if (b == 3'd7 && r == 8'h18) tag = "R6";
      else if (b == 3'd7) tag = "R7";
      else if (b == 3'd1) tag = "R8";
      else tag = w ? "R2" : "R3";
      w0 = wr_cnt; r0 = rd_cnt;
      frame(w, b, s, r, d, w ? 6 : 8, rdat, early, tail);
      if (w) begin
        chk(wr_cnt - w0 == (lg ? 1 : 0) && rd_cnt == r0, {tag, " write strobe count"}, wr_cnt - w0, lg);
        if (lg) begin
          chk(cap_wd == d, "R2 write data", cap_wd, d);
          chk({cap_blk, cap_sub, cap_reg} == {b, s, r}, "R1 write fields", {cap_blk, cap_sub, cap_reg}, {b, s, r});
        end
      end else begin
        chk(rd_cnt - r0 == (lg ? 1 : 0) && wr_cnt == w0, {tag, " read strobe count"}, rd_cnt - r0, lg);
        chk(rdat == e, {tag, " read data"}, rdat, e);
        if (lg) chk({cap_blk, cap_sub, cap_reg} == {b, s, r}, "R1 read fields", {cap_blk, cap_sub, cap_reg}, {b, s, r});
      end
    end

    // R3 strobe issued before the pad bytes
    frame(1'b0, 3'd1, 4'd6, 8'h00, 0, 8, rdat, early, tail);
    chk(early == 1, "R3 early read strobe", early, 1);

    // R5 aborted write leaves scratch untouched and next frame decodes fresh
    w0 = wr_cnt;
    frame(1'b1, 3'd1, 4'd6, 8'h00, 32'h11223344, 4, rdat, early, tail);
    chk(wr_cnt == w0, "R5 no strobe on abort", wr_cnt - w0, 0);
    frame(1'b0, 3'd1, 4'd6, 8'h00, 0, 8, rdat, early, tail);
    chk(rdat == 32'hDEADBEEF, "R5 scratch after abort", rdat, 32'hDEADBEEF);

    // R10 extra bytes after write and read frames
    w0 = wr_cnt;
    frame(1'b1, 3'd1, 4'd6, 8'h00, 32'h0BADF00D, 9, rdat, early, tail);
    chk(wr_cnt - w0 == 1, "R10 single write strobe", wr_cnt - w0, 1);
    r0 = rd_cnt;
    frame(1'b0, 3'd1, 4'd6, 8'h00, 0, 10, rdat, early, tail);
    chk(rd_cnt - r0 == 1 && rdat == 32'h0BADF00D, "R10 single read", rdat, 32'h0BADF00D);
    chk(tail == 8'h00, "R10 tail miso", tail, 0);

    // R7 pointer wrap at depth 16
    frame(1'b1, 3'd7, 4'd0, 8'h11, 32'd15, 6, rdat, early, tail);
    frame(1'b1, 3'd7, 4'd0, 8'h12, 32'h77, 6, rdat, early, tail);
    frame(1'b0, 3'd7, 4'd0, 8'h11, 0, 8, rdat, early, tail);
    chk(rdat == 0, "R7 pointer wrap", rdat, 0);
    frame(1'b1, 3'd7, 4'd0, 8'h11, 32'd15, 6, rdat, early, tail);
    frame(1'b0, 3'd7, 4'd0, 8'h12, 0, 8, rdat, early, tail);
    chk(rdat == 32'h77, "R7 byte at top", rdat, 32'h77);

    // R11 strobes never overlap
    chk(both_hi == 0, "R11 overlap", both_hi, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule